// File: doc/BRIEF.md
# Carry-less Multiply Element Unit

This unit multiplies two elements as polynomials over GF(2): partial products are combined with XOR and no carries propagate. Each operation returns either the lower or the upper SEW bits of the 2*SEW-bit product. The element width is chosen per operation and may be 32 or 64 bits. The first operand is always the per-element multiplicand. The second operand is either a per-element vector value or a scalar register value that is fitted to the element width.

A sequencer outside the unit walks the element indices in order and presents one element per cycle. Each element carries its own width code, half select, scalar select and mask information. Every operation takes exactly one cycle, whatever the data or the width. A reserved width code raises an illegal flag and writes no result. An element whose mask bit is clear produces no result, and the last result stays on the output.

Top module: `clmul_elem_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_illegal` and `out_data` are all zero.
- R2: With `in_high`=0, the result is the lower SEW bits of the carry-less product of the multiplicand and the second operand. It appears on `out_data`, with `out_valid`=1, exactly one clock edge after the operation is accepted.
- R3: With `in_high`=1, the result is bits 2*SEW-1 down to SEW of the same product. A multiplier equal to 1 gives a zero result.
- R4: Width codes on `in_sew`: 2'b10 selects 32-bit elements and 2'b11 selects 64-bit elements. 2'b00 and 2'b01 are reserved. A valid operation with a reserved code pulses `out_illegal` one cycle later, gives no `out_valid`, and leaves `out_data` unchanged.
- R5: With `in_scalar`=1, the second operand is `in_rs1`, zero-extended or truncated to SEW. `in_vs1` has no effect on the result.
- R6: With `in_scalar`=0, the second operand is `in_vs1`, and `in_rs1` has no effect on the result.
- R7: With 32-bit elements, operand bits 63:32 have no effect, and bits 63:32 of the result are zero.
- R8: If `in_mask_en`=1 and `in_mask_bit`=0, the element gives no `out_valid`, and `out_data` keeps its previous value. If `in_mask_en`=0, `in_mask_bit` has no effect.
- R9: Latency is fixed at one cycle for both widths and all data. Operations can be accepted on consecutive cycles, and each one gives its own result on the following cycle.
- R10: A reserved width code raises `out_illegal` even when the element is masked off. `out_valid` and `out_illegal` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_sew | input | 2 | Element width code (2'b10 = 32, 2'b11 = 64, others reserved) |
| in_high | input | 1 | 0 = lower product half, 1 = upper product half |
| in_scalar | input | 1 | 1 = take second operand from `in_rs1` |
| in_mask_en | input | 1 | Masking active for this element |
| in_mask_bit | input | 1 | Element mask bit (0 = inactive when masking) |
| in_vs2 | input | MAX_SEW | Multiplicand element |
| in_vs1 | input | MAX_SEW | Vector second operand element |
| in_rs1 | input | XLEN | Scalar second operand |
| out_valid | output | 1 | Result written this cycle |
| out_data | output | MAX_SEW | Result element |
| out_illegal | output | 1 | Reserved width seen on the previous operation |

## Verification
Two functions can land on the same element: the width check and the mask suppression, when a reserved width code arrives on a masked-off element. The bench provokes this directly and also by chance, since random operations mix reserved codes with random mask bits. It expects the illegal flag with no valid output and an unchanged result register. A second overlap happens when back-to-back operations switch width and half on every cycle. There each output cycle is compared against the operation issued on the edge before it.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  typedef enum logic [1:0] {
    SEW_CODE_8  = 2'b00,
    SEW_CODE_16 = 2'b01,
    SEW_CODE_32 = 2'b10,
    SEW_CODE_64 = 2'b11
  } sew_code_e;

  function automatic logic sew_is_legal(input logic [1:0] code);
    return (code == SEW_CODE_32) || (code == SEW_CODE_64);
  endfunction
endpackage

// File: rtl/clmul_opsel.sv
module clmul_opsel #(
  parameter int MAX_SEW = 64,
  parameter int XLEN    = 64
) (
  input  logic               narrow,
  input  logic               use_scalar,
  input  logic [MAX_SEW-1:0] vs2,
  input  logic [MAX_SEW-1:0] vs1,
  input  logic [XLEN-1:0]    rs1,
  output logic [MAX_SEW-1:0] op_a,
  output logic [MAX_SEW-1:0] op_b
);
  localparam int HALF = MAX_SEW / 2;

  logic [MAX_SEW-1:0] rs1_fit;
  logic [MAX_SEW-1:0] keep;

  generate
    if (XLEN >= MAX_SEW) begin : g_trunc
      assign rs1_fit = rs1[MAX_SEW-1:0];
    end else begin : g_zext
      assign rs1_fit = {{(MAX_SEW-XLEN){1'b0}}, rs1};
    end
  endgenerate

  assign keep = narrow ? {{HALF{1'b0}}, {HALF{1'b1}}} : {MAX_SEW{1'b1}};

  always_comb begin
    op_a = vs2 & keep;
    op_b = (use_scalar ? rs1_fit : vs1) & keep;
  end
endmodule

// File: rtl/clmul_core.sv
module clmul_core #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] rows [W];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_row
      assign rows[gi] = ({{W{1'b0}}, a} << gi) & {(2*W){b[gi]}};
    end
  endgenerate

  always_comb begin
    prod = '0;
    for (int i = 0; i < W; i++) begin
      prod = prod ^ rows[i];
    end
  end
endmodule

// File: rtl/clmul_halfsel.sv
module clmul_halfsel #(
  parameter int W = 64
) (
  input  logic           narrow,
  input  logic           high,
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   res
);
  localparam int HALF = W / 2;

  always_comb begin
    if (narrow) begin
      res = high ? {{HALF{1'b0}}, prod[W-1:HALF]} : {{HALF{1'b0}}, prod[HALF-1:0]};
    end else begin
      res = high ? prod[2*W-1:W] : prod[W-1:0];
    end
  end
endmodule

// File: rtl/clmul_elem_unit.sv
module clmul_elem_unit
  import clmul_pkg::*;
#(
  parameter int MAX_SEW = 64,
  parameter int XLEN    = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_sew,
  input  logic               in_high,
  input  logic               in_scalar,
  input  logic               in_mask_en,
  input  logic               in_mask_bit,
  input  logic [MAX_SEW-1:0] in_vs2,
  input  logic [MAX_SEW-1:0] in_vs1,
  input  logic [XLEN-1:0]    in_rs1,
  output logic               out_valid,
  output logic [MAX_SEW-1:0] out_data,
  output logic               out_illegal
);
  localparam int PW = 2 * MAX_SEW;

  logic               narrow;
  logic               legal;
  logic               active;
  logic               fire;
  logic [MAX_SEW-1:0] op_a;
  logic [MAX_SEW-1:0] op_b;
  logic [PW-1:0]      prod;
  logic [MAX_SEW-1:0] half_res;

  assign narrow = (in_sew == SEW_CODE_32);
  assign legal  = sew_is_legal(in_sew);
  assign active = !(in_mask_en && !in_mask_bit);
  assign fire   = in_valid && legal && active;

  clmul_opsel #(.MAX_SEW(MAX_SEW), .XLEN(XLEN)) opsel_i (
    .narrow(narrow), .use_scalar(in_scalar),
    .vs2(in_vs2), .vs1(in_vs1), .rs1(in_rs1),
    .op_a(op_a), .op_b(op_b)
  );

  clmul_core #(.W(MAX_SEW)) core_i (
    .a(op_a), .b(op_b), .prod(prod)
  );

  clmul_halfsel #(.W(MAX_SEW)) halfsel_i (
    .narrow(narrow), .high(in_high), .prod(prod), .res(half_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= fire;
      out_illegal <= in_valid && !legal;
      if (fire) begin
        out_data <= half_res;
      end
    end
  end
endmodule

// File: rtl/clmul_elem_unit_chk.sv
module clmul_elem_unit_chk #(
  parameter int MAX_SEW = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [1:0]         in_sew,
  input logic               in_mask_en,
  input logic               in_mask_bit,
  input logic               out_valid,
  input logic               out_illegal,
  input logic [MAX_SEW-1:0] out_data
);
  localparam int HALF = MAX_SEW / 2;

  // R10: flag and result never together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal));

  // R9: a result only follows an accepted operation
  a_r9_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && !$past(rst)));

  // R9: fixed one-cycle latency for legal, active elements
  a_r9_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && !rst && in_sew[1] && !(in_mask_en && !in_mask_bit))) |-> out_valid);

  // R4: reserved width raises the flag
  a_r4_reserved_flag: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && !rst && !in_sew[1])) |-> (out_illegal && $stable(out_data)));

  // R8: masked-off element holds the result
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && !rst && in_mask_en && !in_mask_bit)) |-> (!out_valid && $stable(out_data)));

  // R7: narrow results have a clear upper half
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_sew) == 2'b10) |-> (out_data[MAX_SEW-1:HALF] == '0));
endmodule

bind clmul_elem_unit clmul_elem_unit_chk #(.MAX_SEW(MAX_SEW)) chk_i (.*);

// File: tb/clmul_elem_unit_tb_top.sv
`timescale 1ns/1ps
module clmul_elem_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_high, in_scalar, in_mask_en, in_mask_bit;
  logic [1:0]  in_sew;
  logic [63:0] in_vs2, in_vs1, in_rs1;
  logic        out_valid, out_illegal;
  logic [63:0] out_data;

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [63:0] exp_data = '0;
  int          cycles   = 0;
  logic        done     = 1'b0;

  always #2.5 clk = ~clk;

  clmul_elem_unit #(.MAX_SEW(64), .XLEN(64)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sew(in_sew),
    .in_high(in_high), .in_scalar(in_scalar), .in_mask_en(in_mask_en),
    .in_mask_bit(in_mask_bit), .in_vs2(in_vs2), .in_vs1(in_vs1),
    .in_rs1(in_rs1), .out_valid(out_valid), .out_data(out_data),
    .out_illegal(out_illegal)
  );

  function automatic logic [63:0] ref_res(input logic [63:0] x, input logic [63:0] y,
                                          input logic wide, input logic high);
    int w = wide ? 64 : 32;
    logic [63:0] m = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    logic [63:0] r = '0;
    x = x & m;
    y = y & m;
    if (!high) begin
      for (int i = 0; i < w; i++) if (y[i]) r = r ^ (x << i);
    end else begin
      for (int i = 1; i < w; i++) if (y[i]) r = r ^ (x >> (w - i));
    end
    return r & m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic v, input logic [1:0] sew,
                    input logic high, input logic scalar, input logic men,
                    input logic mbit, input logic [63:0] vs2,
                    input logic [63:0] vs1, input logic [63:0] rs1);
    logic legal = sew[1];
    logic fire  = v && legal && !(men && !mbit);
    in_valid = v; in_sew = sew; in_high = high; in_scalar = scalar;
    in_mask_en = men; in_mask_bit = mbit; in_vs2 = vs2; in_vs1 = vs1; in_rs1 = rs1;
    @(negedge clk);
    if (fire) exp_data = ref_res(vs2, scalar ? rs1 : vs1, sew[0], high);
    check({req, " valid"},   {63'd0, out_valid},   {63'd0, fire});
    check({req, " illegal"}, {63'd0, out_illegal}, {63'd0, v && !legal});
    check({req, " data"},    out_data, exp_data);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, s;
    rst = 1'b1; in_valid = 0; in_sew = 2'b11; in_high = 0; in_scalar = 0;
    in_mask_en = 0; in_mask_bit = 0; in_vs2 = 0; in_vs1 = 0; in_rs1 = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    check("R1 illegal", {63'd0, out_illegal}, 64'd0);
    check("R1 data", out_data, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {62'd0, out_valid, out_illegal}, 64'd0);

    // R2 / R3 directed
    op("R2 identity", 1, 2'b11, 0, 0, 0, 0, 64'hDEAD_BEEF_0123_4567, 64'd1, 64'hFF);
    check("R2 identity value", out_data, 64'hDEAD_BEEF_0123_4567);
    op("R3 mult one", 1, 2'b11, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
    check("R3 mult one zero", out_data, 64'd0);
    op("R3 all ones", 1, 2'b11, 1, 0, 0, 0, '1, '1, 64'd0);
    op("R2 x3 narrow", 1, 2'b10, 0, 0, 0, 0, 64'd3, 64'd3, 64'd0);
    check("R2 x3 value", out_data, 64'd5);
    // R7: upper operand bits ignored in narrow mode
    op("R7 narrow hi", 1, 2'b10, 1, 0, 0, 0, 64'hAAAA_5555_8000_0001, 64'h1234_0000_8000_0003, 64'd0);
    check("R7 upper zero", {32'd0, out_data[63:32]}, 64'd0);
    // R5: scalar form, vs1 ignored, rs1 truncated to 32
    op("R5 scalar", 1, 2'b10, 0, 1, 0, 0, 64'h0000_0000_0000_00F0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h9999_0000_0000_0002);
    check("R5 scalar value", out_data, 64'h1E0);
    // R6: vector form, rs1 ignored
    op("R6 vector", 1, 2'b11, 0, 0, 0, 0, 64'h10, 64'h2, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 vector value", out_data, 64'h20);
    // R8: masked-off holds, mask bit ignored when disabled
    op("R8 masked", 1, 2'b11, 0, 0, 1, 0, 64'h77, 64'h5, 64'd0);
    check("R8 hold", out_data, 64'h20);
    op("R8 mask off bit", 1, 2'b11, 0, 0, 0, 0, 64'h3, 64'h3, 64'd0);
    op("R8 mask active", 1, 2'b10, 1, 1, 1, 1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'd0);
    // R4: reserved codes
    op("R4 code00", 1, 2'b00, 0, 0, 0, 0, 64'h5, 64'h5, 64'd0);
    op("R4 code01", 1, 2'b01, 1, 1, 0, 0, 64'h5, 64'h5, 64'h5);
    // R10: reserved and masked together
    op("R10 reserved masked", 1, 2'b01, 0, 0, 1, 0, 64'h9, 64'h9, 64'd0);
    // R9: back-to-back alternating width and half
    for (int k = 0; k < 16; k++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      op("R9 back-to-back", 1, {1'b1, k[0]}, k[1], k[2], 0, 0, a, b, ~b);
    end
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ctl = $urandom;
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; s = {$urandom, $urandom};
      if (ctl[8]) a = a & 64'h8000_0000_0000_0001;
      op(ctl[2] ? "R3 random" : "R2 random", ctl[7:0] != 8'h00, ctl[1:0] | {ctl[9] | ctl[10], 1'b0},
         ctl[2], ctl[3], ctl[4], ctl[5] | ctl[6], a, b, s);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule